// File: doc/BRIEF.md
# Multi-Source Acquisition Trigger Aligner

This block collects trigger requests from several sources and merges them into one acquisition trigger. The sources are one external input, one internal threshold pulse per channel, a software pulse, and two time-of-day pulses (primary and alternate). Each source reaches the block with a different built-in latency. The block gives each source its own fixed pipeline delay so that every request lines up with a sample stream. That sample stream is itself held back by three clock cycles inside the block.

The external input is a level. Its active edge is chosen by a polarity input. A nonzero hold-off count can delay the external request by that many additional cycles. While that count is running, a busy output is high and further external edges are dropped. Every source has its own enable, applied at the point where the request enters its delay line. The merged output is the OR of all aligned lines, so pulses that arrive close together are all kept.

Top module: `trig_align`

## Requirements
- R1: `smp_o` equals `smp_i` from exactly three cycles earlier. It is zero for the first three cycles after reset.
- R2: An enabled internal channel pulse present in cycle c makes `trig_o` high in cycle c+3.
- R3: An enabled software pulse in cycle c makes `trig_o` high in cycle c+12.
- R4: An enabled primary time pulse in cycle c, or an enabled alternate time pulse in cycle c, makes `trig_o` high in cycle c+12. The two paths are independent.
- R5: With a hold-off of 0, an enabled external edge seen in cycle c makes `trig_o` high in cycle c+10. An edge in cycle c means the input level in cycle c differs from its level in cycle c-1.
- R6: With `ext_pol_i` = 0 only rising edges count. With `ext_pol_i` = 1 only falling edges count. The other edge produces no trigger.
- R7: With a hold-off D > 0, an accepted edge in cycle c drives `ext_busy_o` high in cycles c+1 through c+D and makes `trig_o` high in cycle c+D+10. It produces exactly one pulse.
- R8: External edges seen while `ext_busy_o` is high are ignored. They produce no trigger and do not restart the count.
- R9: A pulse on a source whose enable is low in that cycle never appears on `trig_o`. Other enabled sources are unaffected.
- R10: Pulses on one source in consecutive cycles each yield their own `trig_o` cycle, with none lost.
- R11: When several aligned pulses fall in the same cycle, `trig_o` is high for that one cycle only.
- R12: During and right after reset, `trig_o` and `ext_busy_o` are low and `smp_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | SMP_W | Sample stream in |
| smp_o | output | SMP_W | Sample stream delayed by the data alignment |
| ch_trig_i | input | N_CH | Per-channel threshold pulses |
| ch_en_i | input | N_CH | Per-channel enables |
| ext_lvl_i | input | 1 | External trigger level |
| ext_pol_i | input | 1 | 0: rising edge, 1: falling edge |
| ext_en_i | input | 1 | External source enable |
| ext_hold_i | input | CNT_W | Extra external hold-off in cycles |
| ext_busy_o | output | 1 | Hold-off count running |
| sw_trig_i | input | 1 | Software trigger pulse |
| sw_en_i | input | 1 | Software source enable |
| tod_trig_i | input | 1 | Primary time trigger pulse |
| tod_en_i | input | 1 | Primary time enable |
| tod_alt_trig_i | input | 1 | Alternate time trigger pulse |
| tod_alt_en_i | input | 1 | Alternate time enable |
| trig_o | output | 1 | Merged aligned acquisition trigger |

## Verification
The bench builds the block with its default values: four channels, 16-bit samples, a 32-bit hold-off and the alignment lengths 3, 10 and 12. At these lengths every source's latency fits inside a 40-cycle window after a fresh reset. In each window the bench compares `trig_o`, `ext_busy_o` and `smp_o` in every cycle against expected traces computed from the event cycles. A hold-off of 5 lets a whole busy period, an ignored edge inside it and a second accepted edge all happen in one window.

// File: rtl/trig_align_pkg.sv
package trig_align_pkg;
  localparam int unsigned DEF_SMP_DLY  = 3;
  localparam int unsigned DEF_EXT_COMP = 7;
  localparam int unsigned DEF_TOD_COMP = 9;
  localparam int unsigned DEF_SW_COMP  = 9;

  typedef enum logic {
    POL_RISE = 1'b0,
    POL_FALL = 1'b1
  } pol_e;
endpackage

// File: rtl/trig_delay_line.sv
module trig_delay_line #(
  parameter int unsigned W   = 1,
  parameter int unsigned LEN = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [LEN];

  for (genvar i = 0; i < LEN; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= '0;
        else         stage_q[i] <= d_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= '0;
        else         stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[LEN-1];
endmodule

// File: rtl/ext_trig_cond.sv
module ext_trig_cond
  import trig_align_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             pol_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic             busy_o,
  output logic             fire_o
);
  logic             lvl_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             edge_hit;
  logic             arm;
  logic             last_tick;

  always_comb begin
    if (pol_e'(pol_i) == POL_FALL) edge_hit = lvl_q & ~lvl_i;
    else                           edge_hit = lvl_i & ~lvl_q;
  end

  // edges during a running hold-off are dropped
  assign arm       = edge_hit & en_i & ~busy_q;
  assign last_tick = busy_q && (cnt_q == CNT_W'(1));
  assign fire_o    = last_tick | (arm && (hold_i == '0));
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      lvl_q <= lvl_i;
      if (arm && (hold_i != '0)) begin
        busy_q <= 1'b1;
        cnt_q  <= hold_i;
      end else if (busy_q) begin
        if (last_tick) busy_q <= 1'b0;
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/trig_align.sv
module trig_align
  import trig_align_pkg::*;
#(
  parameter int unsigned N_CH     = 4,
  parameter int unsigned SMP_W    = 16,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned SMP_DLY  = DEF_SMP_DLY,
  parameter int unsigned EXT_COMP = DEF_EXT_COMP,
  parameter int unsigned TOD_COMP = DEF_TOD_COMP,
  parameter int unsigned SW_COMP  = DEF_SW_COMP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] smp_i,
  output logic [SMP_W-1:0] smp_o,
  input  logic [N_CH-1:0]  ch_trig_i,
  input  logic [N_CH-1:0]  ch_en_i,
  input  logic             ext_lvl_i,
  input  logic             ext_pol_i,
  input  logic             ext_en_i,
  input  logic [CNT_W-1:0] ext_hold_i,
  output logic             ext_busy_o,
  input  logic             sw_trig_i,
  input  logic             sw_en_i,
  input  logic             tod_trig_i,
  input  logic             tod_en_i,
  input  logic             tod_alt_trig_i,
  input  logic             tod_alt_en_i,
  output logic             trig_o
);
  // every trigger path also absorbs the sample delay
  localparam int unsigned EXT_LEN = EXT_COMP + SMP_DLY;
  localparam int unsigned TOD_LEN = TOD_COMP + SMP_DLY;
  localparam int unsigned SW_LEN  = SW_COMP + SMP_DLY;

  logic [N_CH-1:0] ch_al;
  logic            ext_fire;
  logic            ext_al;
  logic            sw_al;
  logic            tod_al;
  logic            alt_al;

  trig_delay_line #(.W(SMP_W), .LEN(SMP_DLY)) u_smp_dl (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(smp_i), .q_o(smp_o)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    trig_delay_line #(.W(1), .LEN(SMP_DLY)) u_ch_dl (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .d_i(ch_trig_i[g] & ch_en_i[g]), .q_o(ch_al[g])
    );
  end

  ext_trig_cond #(.CNT_W(CNT_W)) u_ext (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lvl_i(ext_lvl_i), .pol_i(ext_pol_i), .en_i(ext_en_i),
    .hold_i(ext_hold_i), .busy_o(ext_busy_o), .fire_o(ext_fire)
  );

  trig_delay_line #(.W(1), .LEN(EXT_LEN)) u_ext_dl (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_fire), .q_o(ext_al)
  );

  trig_delay_line #(.W(1), .LEN(SW_LEN)) u_sw_dl (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sw_trig_i & sw_en_i), .q_o(sw_al)
  );

  trig_delay_line #(.W(1), .LEN(TOD_LEN)) u_tod_dl (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(tod_trig_i & tod_en_i), .q_o(tod_al)
  );

  trig_delay_line #(.W(1), .LEN(TOD_LEN)) u_alt_dl (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(tod_alt_trig_i & tod_alt_en_i), .q_o(alt_al)
  );

  assign trig_o = (|ch_al) | ext_al | sw_al | tod_al | alt_al;
endmodule

// File: rtl/trig_align_chk.sv
module trig_align_chk #(
  parameter int unsigned SMP_W = 16,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SMP_W-1:0] smp_i,
  input logic [SMP_W-1:0] smp_o,
  input logic             ch0_trig_i,
  input logic             ch0_en_i,
  input logic             ext_en_i,
  input logic [CNT_W-1:0] ext_hold_i,
  input logic             ext_busy_o,
  input logic             ext_fire_i,
  input logic             trig_o
);
  logic [2:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
  end

  p_smp_delay_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 3'd3) |-> (smp_o == $past(smp_i, 3)));

  p_ch_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cyc_q >= 3'd3) && $past(ch0_trig_i && ch0_en_i, 3)) |-> trig_o);

  p_busy_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_busy_o) |-> ($past(ext_en_i) && ($past(ext_hold_i) != '0)));

  p_busy_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_busy_o) |-> $past(ext_fire_i));

  p_fire_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_fire_i |-> (ext_busy_o || (ext_hold_i == '0)));
endmodule

bind trig_align trig_align_chk #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .smp_i(smp_i),
  .smp_o(smp_o),
  .ch0_trig_i(ch_trig_i[0]),
  .ch0_en_i(ch_en_i[0]),
  .ext_en_i(ext_en_i),
  .ext_hold_i(ext_hold_i),
  .ext_busy_o(ext_busy_o),
  .ext_fire_i(ext_fire),
  .trig_o(trig_o)
);

// File: tb/tb_trig_align.sv
`timescale 1ns/1ps
module tb_trig_align;
  localparam int L = 40;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] smp_i = '0;
  logic [15:0] smp_o;
  logic [3:0]  ch_trig_i = '0;
  logic [3:0]  ch_en_i = '0;
  logic        ext_lvl_i = 1'b0;
  logic        ext_pol_i = 1'b0;
  logic        ext_en_i = 1'b0;
  logic [31:0] ext_hold_i = '0;
  logic        ext_busy_o;
  logic        sw_trig_i = 1'b0, sw_en_i = 1'b0;
  logic        tod_trig_i = 1'b0, tod_en_i = 1'b0;
  logic        tod_alt_trig_i = 1'b0, tod_alt_en_i = 1'b0;
  logic        trig_o;

  always #5 clk_i = ~clk_i;

  trig_align dut (.*);

  int n_cmp = 0;
  int n_bad = 0;

  logic [3:0] s_ch  [L];
  logic       s_sw  [L];
  logic       s_tod [L];
  logic       s_alt [L];
  logic       s_ext [L];
  logic       e_trig[L];
  logic       e_busy[L];

  function automatic logic [15:0] smp_at(int c);
    return 16'((c * 37 + 5) & 16'hffff);
  endfunction

  task automatic chk(bit ok, string req, int cyc, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic clr_scn(logic idle_lvl);
    for (int i = 0; i < L; i++) begin
      s_ch[i] = '0; s_sw[i] = 0; s_tod[i] = 0; s_alt[i] = 0;
      s_ext[i] = idle_lvl; e_trig[i] = 0; e_busy[i] = 0;
    end
    ch_en_i = 4'hf; sw_en_i = 1; tod_en_i = 1; tod_alt_en_i = 1; ext_en_i = 1;
    ext_pol_i = 0; ext_hold_i = '0;
  endtask

  task automatic lvl_from(int from, logic v);
    for (int i = from; i < L; i++) s_ext[i] = v;
  endtask

  task automatic run_scn(string req);
    @(negedge clk_i);
    rst_ni = 0;
    ch_trig_i = '0; sw_trig_i = 0; tod_trig_i = 0; tod_alt_trig_i = 0;
    smp_i = '0; ext_lvl_i = s_ext[0];
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    for (int c = 0; c < L; c++) begin
      if (c == 0) begin
        chk(trig_o == 0 && ext_busy_o == 0 && smp_o == 0, "R12", c,
            {trig_o, ext_busy_o}, 0);
      end
      chk(trig_o == e_trig[c], req, c, trig_o, e_trig[c]);
      chk(ext_busy_o == e_busy[c], "R7 busy", c, ext_busy_o, e_busy[c]);
      chk(smp_o == ((c >= 3) ? smp_at(c - 3) : 16'd0), "R1", c, smp_o,
          (c >= 3) ? smp_at(c - 3) : 0);
      ch_trig_i = s_ch[c]; sw_trig_i = s_sw[c]; tod_trig_i = s_tod[c];
      tod_alt_trig_i = s_alt[c]; ext_lvl_i = s_ext[c]; smp_i = smp_at(c);
      @(negedge clk_i);
    end
  endtask

  initial begin
    // R2 channels, simultaneous channels merged (R11)
    clr_scn(0);
    s_ch[2] = 4'b0001; s_ch[5] = 4'b1110;
    e_trig[5] = 1; e_trig[8] = 1;
    run_scn("R2");

    // R3 software, back-to-back pulses R10
    clr_scn(0);
    s_sw[1] = 1; s_sw[2] = 1; s_sw[3] = 1;
    e_trig[13] = 1; e_trig[14] = 1; e_trig[15] = 1;
    run_scn("R3 R10");

    // R4 primary and alternate time paths
    clr_scn(0);
    s_tod[2] = 1; s_alt[6] = 1;
    e_trig[14] = 1; e_trig[18] = 1;
    run_scn("R4");

    // R5 and R6 rising polarity: rise at 3, fall at 9 ignored
    clr_scn(0);
    lvl_from(3, 1); lvl_from(9, 0);
    e_trig[13] = 1;
    run_scn("R5 R6 rise");

    // R6 falling polarity: fall at 3, rise at 8 ignored
    clr_scn(1);
    ext_pol_i = 1;
    lvl_from(3, 0); lvl_from(8, 1);
    e_trig[13] = 1;
    run_scn("R6 fall");

    // R7 hold-off 5; R8 rise at 6 during busy ignored; rise at 8 accepted
    clr_scn(0);
    ext_hold_i = 32'd5;
    lvl_from(2, 1); lvl_from(4, 0); lvl_from(6, 1); lvl_from(7, 0); lvl_from(8, 1);
    for (int i = 3; i <= 7; i++) e_busy[i] = 1;
    for (int i = 9; i <= 13; i++) e_busy[i] = 1;
    e_trig[17] = 1; e_trig[23] = 1;
    run_scn("R7 R8");

    // R9 disabled sources: only channel 2 (enabled) passes
    clr_scn(0);
    ch_en_i = 4'b0101; sw_en_i = 0; tod_en_i = 0; tod_alt_en_i = 0; ext_en_i = 0;
    s_ch[2] = 4'b0010; s_ch[6] = 4'b0100;
    s_sw[3] = 1; s_tod[4] = 1; s_alt[5] = 1;
    lvl_from(7, 1);
    e_trig[9] = 1;
    run_scn("R9");

    // R11 three sources aligned to cycle 12 give one cycle
    clr_scn(0);
    s_sw[0] = 1; s_tod[0] = 1; s_ch[9] = 4'b1000;
    e_trig[12] = 1;
    run_scn("R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule